// File: doc/BRIEF.md
# Dual-Sided Messaging Unit

Two processors, each with its own register bus, exchange 32-bit words and doorbell events through this block. Each side owns four outgoing mailbox words. A word written on one side shows up on the partner side as the incoming word of the same channel. One flag per mailbox word tracks progress. It says whether the word is waiting for the partner, or whether the slot is free for a new word. Software on either side polls these flags, or lets them raise an interrupt.

A side may also ring any of four doorbells. The request bit in its own control register is a one-shot. It sets a sticky pending bit on the far side, and software there acknowledges that bit by writing a one to it. Each flag can be enabled as an interrupt source, and each side has one interrupt line. A build-time parameter chooses between two bit arrangements for flags and enables. In the packed legacy arrangement all flags share one status word and all enables share one control word, in reversed channel order. In the compact arrangement every flag group has its own register, and channel x sits at bit x.

Top module: `msg_unit`

## Requirements
- R1: After reset, every slot-free flag is 1, every incoming-word flag and doorbell-pending flag is 0, every control bit is 0, and both interrupt lines are low.
- R2: A write to word address n (0..3) on one side stores the data, which the partner reads at address 4+n. The write clears the writer's slot-free flag n and sets the partner's incoming-word flag n, starting from the next cycle.
- R3: A read of address 4+n returns the incoming word without changing it. On the next cycle the reader's incoming-word flag n is 0 and the partner's slot-free flag n is 1.
- R4: Legacy layout, status word at address 8: doorbell-pending for channel x at bit 31-x, incoming-word at bit 27-x, slot-free at bit 23-x. All other bits read 0.
- R5: Legacy layout, control word at address 9, read/write: doorbell-enable at bit 31-x, incoming-enable at bit 27-x, slot-free-enable at bit 23-x, doorbell-request at bit 19-x.
- R6: Compact layout: channel x is bit x of its own register. Pending is at address 8, incoming at 9, slot-free at 10, doorbell-enable at 11, incoming-enable at 12, slot-free-enable at 13 and doorbell-request at 14.
- R7: A doorbell-request bit reads 1 for exactly one cycle after it is written. On the edge where it drops, the matching doorbell-pending bit on the partner side becomes 1.
- R8: Writing the status register clears each doorbell-pending bit whose position holds a 1. Zero bits, and all bits outside the pending field, have no effect.
- R9: A side's interrupt is high exactly when at least one of its flags is set together with the enable bit for that flag.
- R10: If one side writes address n in the same cycle that the partner reads address 4+n, the read returns the old word, and afterwards the partner's incoming-word flag n is 1 and the writer's slot-free flag n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Asynchronous active-low reset |
| aSel | input | 1 | Side A access strobe |
| aWr | input | 1 | Side A write (1) or read (0) |
| aAddr | input | 4 | Side A word address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data, combinational from aAddr |
| aIrq | output | 1 | Side A interrupt |
| bSel | input | 1 | Side B access strobe |
| bWr | input | 1 | Side B write (1) or read (0) |
| bAddr | input | 4 | Side B word address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data, combinational from bAddr |
| bIrq | output | 1 | Side B interrupt |

## Verification
A flag stuck at the wrong value shows at the ports in two ways. The next read of the status register reports it, and the interrupt line moves within the same cycle once the matching enable is set. A lost doorbell request shows as a partner pending bit that never sets. A request that does not clear itself shows in the control read-back one cycle after the write. A mailbox word written to the wrong slot shows on the partner's first read of that channel. The bench therefore reads status and control after every access that changes them, so a wrong flag is caught within two cycles of the access that caused it.

// File: rtl/msg_unit_pkg.sv
package msg_unit_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  // word address bases
  localparam int TX_BASE  = 0;
  localparam int RX_BASE  = NUM_CH;
  localparam int REG_BASE = 2 * NUM_CH;

  // legacy field bases (channel order reversed inside a field)
  localparam int LEG_GP  = 28;
  localparam int LEG_RF  = 24;
  localparam int LEG_TE  = 20;
  localparam int LEG_GIR = 16;

  typedef struct packed {
    logic [NUM_CH-1:0] loadAB;
    logic [NUM_CH-1:0] loadBA;
  } muStrobes_t;

  typedef struct packed {
    logic [NUM_CH-1:0] gp;
    logic [NUM_CH-1:0] rf;
    logic [NUM_CH-1:0] te;
    logic [NUM_CH-1:0] gie;
    logic [NUM_CH-1:0] rie;
    logic [NUM_CH-1:0] tie;
    logic [NUM_CH-1:0] gir;
  } sideRegs_t;

  localparam sideRegs_t REGS_RST = '{gp: '0, rf: '0, te: '1, gie: '0,
                                     rie: '0, tie: '0, gir: '0};

  function automatic int legPos(input int base, input int ch);
    return base + (NUM_CH - 1 - ch);
  endfunction

  // register read view for one side
  function automatic logic [DATA_W-1:0] regView(input sideRegs_t r, input logic legacy,
                                                input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int x = 0; x < NUM_CH; x++) begin
      if (legacy) begin
        if (a == ADDR_W'(REG_BASE)) begin
          w[legPos(LEG_GP, x)] = r.gp[x];
          w[legPos(LEG_RF, x)] = r.rf[x];
          w[legPos(LEG_TE, x)] = r.te[x];
        end else if (a == ADDR_W'(REG_BASE + 1)) begin
          w[legPos(LEG_GP, x)]  = r.gie[x];
          w[legPos(LEG_RF, x)]  = r.rie[x];
          w[legPos(LEG_TE, x)]  = r.tie[x];
          w[legPos(LEG_GIR, x)] = r.gir[x];
        end
      end else begin
        case (a)
          ADDR_W'(REG_BASE):     w[x] = r.gp[x];
          ADDR_W'(REG_BASE + 1): w[x] = r.rf[x];
          ADDR_W'(REG_BASE + 2): w[x] = r.te[x];
          ADDR_W'(REG_BASE + 3): w[x] = r.gie[x];
          ADDR_W'(REG_BASE + 4): w[x] = r.rie[x];
          ADDR_W'(REG_BASE + 5): w[x] = r.tie[x];
          ADDR_W'(REG_BASE + 6): w[x] = r.gir[x];
          default:               w[x] = 1'b0;
        endcase
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/msg_unit_ctrl.sv
module msg_unit_ctrl
  import msg_unit_pkg::*;
#(
  parameter bit LEGACY = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   sel,
  input  logic [1:0]                   wr,
  input  logic [1:0][ADDR_W-1:0]       addr,
  input  logic [1:0][DATA_W-1:0]       wdata,
  output muStrobes_t                   strobes,
  output sideRegs_t [1:0]              regs,
  output logic [1:0][DATA_W-1:0]       regWord,
  output logic [1:0]                   irq
);
  localparam int GIE_OFS = LEGACY ? 1 : 3;
  localparam int RIE_OFS = LEGACY ? 1 : 4;
  localparam int TIE_OFS = LEGACY ? 1 : 5;
  localparam int GIR_OFS = LEGACY ? 1 : 6;

  logic [1:0][NUM_CH-1:0] txHit, rxHit;
  logic [1:0] isWr, stWr, gieWr, rieWr, tieWr, girWr;
  sideRegs_t [1:0] regsQ, regsD;

  function automatic logic [NUM_CH-1:0] field(input logic [DATA_W-1:0] w, input int base);
    logic [NUM_CH-1:0] f;
    for (int x = 0; x < NUM_CH; x++) f[x] = LEGACY ? w[legPos(base, x)] : w[x];
    return f;
  endfunction

  // access decode
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      isWr[s] = sel[s] & wr[s];
      for (int n = 0; n < NUM_CH; n++) begin
        txHit[s][n] = isWr[s] & (addr[s] == ADDR_W'(TX_BASE + n));
        rxHit[s][n] = sel[s] & ~wr[s] & (addr[s] == ADDR_W'(RX_BASE + n));
      end
      stWr[s]  = isWr[s] & (addr[s] == ADDR_W'(REG_BASE));
      gieWr[s] = isWr[s] & (addr[s] == ADDR_W'(REG_BASE + GIE_OFS));
      rieWr[s] = isWr[s] & (addr[s] == ADDR_W'(REG_BASE + RIE_OFS));
      tieWr[s] = isWr[s] & (addr[s] == ADDR_W'(REG_BASE + TIE_OFS));
      girWr[s] = isWr[s] & (addr[s] == ADDR_W'(REG_BASE + GIR_OFS));
    end
  end

  // flag and control next state; a write beats a same-cycle peer read
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      regsD[s]    = regsQ[s];
      regsD[s].te = (regsQ[s].te | rxHit[1-s]) & ~txHit[s];
      regsD[s].rf = (regsQ[s].rf & ~rxHit[s]) | txHit[1-s];
      regsD[s].gp = (regsQ[s].gp & ~(stWr[s] ? field(wdata[s], LEG_GP) : '0))
                    | regsQ[1-s].gir;
      if (gieWr[s]) regsD[s].gie = field(wdata[s], LEG_GP);
      if (rieWr[s]) regsD[s].rie = field(wdata[s], LEG_RF);
      if (tieWr[s]) regsD[s].tie = field(wdata[s], LEG_TE);
      regsD[s].gir = girWr[s] ? field(wdata[s], LEG_GIR) : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regsQ[0] <= REGS_RST;
      regsQ[1] <= REGS_RST;
    end else begin
      regsQ <= regsD;
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      regWord[s] = regView(regsQ[s], LEGACY, addr[s]);
      irq[s] = |((regsQ[s].gp & regsQ[s].gie) | (regsQ[s].rf & regsQ[s].rie)
                 | (regsQ[s].te & regsQ[s].tie));
    end
  end

  assign strobes.loadAB = txHit[0];
  assign strobes.loadBA = txHit[1];
  assign regs = regsQ;
endmodule

// File: rtl/msg_unit_data.sv
module msg_unit_data
  import msg_unit_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  muStrobes_t             strobes,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic [1:0][DATA_W-1:0] regWord,
  output logic [1:0][DATA_W-1:0] rdata
);
  logic [NUM_CH-1:0][DATA_W-1:0] wordAB, wordBA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAB <= '0;
      wordBA <= '0;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (strobes.loadAB[n]) wordAB[n] <= wdata[0];
        if (strobes.loadBA[n]) wordBA[n] <= wdata[1];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      if (addr[s] < ADDR_W'(RX_BASE))
        rdata[s] = (s == 0) ? wordAB[addr[s][CH_W-1:0]] : wordBA[addr[s][CH_W-1:0]];
      else if (addr[s] < ADDR_W'(REG_BASE))
        rdata[s] = (s == 0) ? wordBA[addr[s][CH_W-1:0]] : wordAB[addr[s][CH_W-1:0]];
      else
        rdata[s] = regWord[s];
    end
  end
endmodule

// File: rtl/msg_unit.sv
module msg_unit
  import msg_unit_pkg::*;
#(
  parameter bit LEGACY_LAYOUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aSel,
  input  logic              aWr,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aIrq,
  input  logic              bSel,
  input  logic              bWr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bIrq
);
  muStrobes_t             strobes;
  sideRegs_t [1:0]        sideRegs;
  logic [1:0][DATA_W-1:0] regWord, rdata;
  logic [1:0]             irq;

  msg_unit_ctrl #(.LEGACY(LEGACY_LAYOUT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sel({bSel, aSel}), .wr({bWr, aWr}),
    .addr({bAddr, aAddr}), .wdata({bWdata, aWdata}),
    .strobes(strobes), .regs(sideRegs), .regWord(regWord), .irq(irq)
  );

  msg_unit_data u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addr({bAddr, aAddr}), .wdata({bWdata, aWdata}),
    .regWord(regWord), .rdata(rdata)
  );

  assign aRdata = rdata[0];
  assign bRdata = rdata[1];
  assign aIrq   = irq[0];
  assign bIrq   = irq[1];
endmodule

// File: rtl/msg_unit_chk.sv
module msg_unit_chk
  import msg_unit_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              aSel,
  input logic              aWr,
  input logic [ADDR_W-1:0] aAddr,
  input logic [DATA_W-1:0] aWdata,
  input logic              aIrq,
  input logic              bSel,
  input logic              bWr,
  input logic [ADDR_W-1:0] bAddr,
  input logic [DATA_W-1:0] bRdata,
  input logic              bIrq,
  input sideRegs_t [1:0]   sideRegs
);
  // R2
  txwr_sets_peer_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aSel && aWr && aAddr < ADDR_W'(RX_BASE)) |=>
      (sideRegs[1].rf[$past(aAddr[CH_W-1:0])] && !sideRegs[0].te[$past(aAddr[CH_W-1:0])]));

  // R2
  word_crosses_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(aSel && aWr && aAddr < ADDR_W'(RX_BASE)) && bSel && !bWr &&
     bAddr == (ADDR_W'(RX_BASE) + ADDR_W'($past(aAddr[CH_W-1:0])))) |->
      bRdata == $past(aWdata));

  // R3
  rxrd_drains_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bSel && !bWr && bAddr >= ADDR_W'(RX_BASE) && bAddr < ADDR_W'(REG_BASE) &&
     !(aSel && aWr && aAddr == bAddr - ADDR_W'(RX_BASE))) |=>
      (!sideRegs[1].rf[$past(bAddr[CH_W-1:0])] && sideRegs[0].te[$past(bAddr[CH_W-1:0])]));

  // R7
  bell_reaches_peer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sideRegs[0].gir) |=>
      ((sideRegs[1].gp & $past(sideRegs[0].gir)) == $past(sideRegs[0].gir)));

  // R8
  pending_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(sideRegs[0].gp) & ~sideRegs[0].gp)) |-> $past(aSel && aWr));

  // R9
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sideRegs[1].gie == '0 && sideRegs[1].rie == '0 && sideRegs[1].tie == '0) |-> !bIrq);
endmodule

bind msg_unit msg_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .aSel(aSel), .aWr(aWr), .aAddr(aAddr), .aWdata(aWdata),
  .aIrq(aIrq), .bSel(bSel), .bWr(bWr), .bAddr(bAddr), .bRdata(bRdata), .bIrq(bIrq),
  .sideRegs(sideRegs)
);

// File: tb/msg_unit_tb.sv
module msg_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // index [dut][side]: dut 0 legacy, dut 1 compact; side 0 = A, 1 = B
  logic        sel   [2][2];
  logic        wr    [2][2];
  logic [3:0]  addr  [2][2];
  logic [31:0] wdata [2][2];
  logic [31:0] rdata [2][2];
  logic        irq   [2][2];

  msg_unit #(.LEGACY_LAYOUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN),
    .aSel(sel[0][0]), .aWr(wr[0][0]), .aAddr(addr[0][0]), .aWdata(wdata[0][0]),
    .aRdata(rdata[0][0]), .aIrq(irq[0][0]),
    .bSel(sel[0][1]), .bWr(wr[0][1]), .bAddr(addr[0][1]), .bWdata(wdata[0][1]),
    .bRdata(rdata[0][1]), .bIrq(irq[0][1]));

  msg_unit #(.LEGACY_LAYOUT(1'b0)) u_dutCompact (
    .clk(clk), .rstN(rstN),
    .aSel(sel[1][0]), .aWr(wr[1][0]), .aAddr(addr[1][0]), .aWdata(wdata[1][0]),
    .aRdata(rdata[1][0]), .aIrq(irq[1][0]),
    .bSel(sel[1][1]), .bWr(wr[1][1]), .bAddr(addr[1][1]), .bWdata(wdata[1][1]),
    .bRdata(rdata[1][1]), .bIrq(irq[1][1]));

  typedef struct { string tag; logic [31:0] val; } expItem_t;
  expItem_t    expQ[$];
  logic [31:0] actQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // monitor: pairs observed values with expectations
  always @(negedge clk) begin
    while (expQ.size() > 0 && actQ.size() > 0) begin
      expItem_t e;
      logic [31:0] a;
      e = expQ.pop_front();
      a = actQ.pop_front();
      compared++;
      if (a !== e.val) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", e.tag, a, e.val);
      end
    end
  end

  task automatic busWrite(int d, int s, logic [3:0] a, logic [31:0] v);
    @(negedge clk);
    sel[d][s] = 1'b1; wr[d][s] = 1'b1; addr[d][s] = a; wdata[d][s] = v;
    @(negedge clk);
    sel[d][s] = 1'b0; wr[d][s] = 1'b0;
  endtask

  task automatic busRead(int d, int s, logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    sel[d][s] = 1'b1; wr[d][s] = 1'b0; addr[d][s] = a;
    #1 v = rdata[d][s];
    @(negedge clk);
    sel[d][s] = 1'b0;
  endtask

  task automatic readCheck(int d, int s, logic [3:0] a, string tag, logic [31:0] e);
    logic [31:0] v;
    expQ.push_back('{tag, e});
    busRead(d, s, a, v);
    actQ.push_back(v);
  endtask

  // look at a register without a bus access
  task automatic peekCheck(int d, int s, logic [3:0] a, string tag, logic [31:0] e);
    addr[d][s] = a;
    #1;
    expQ.push_back('{tag, e});
    actQ.push_back(rdata[d][s]);
  endtask

  task automatic irqCheck(int d, int s, string tag, logic e);
    expQ.push_back('{tag, {31'b0, e}});
    actQ.push_back({31'b0, irq[d][s]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] oldWord;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++) begin
        sel[d][s] = 1'b0; wr[d][s] = 1'b0; addr[d][s] = '0; wdata[d][s] = '0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // ---------- legacy layout ----------
    readCheck(0, 0, 4'd8, "R1 A status after reset", 32'h00F0_0000);
    readCheck(0, 0, 4'd9, "R1 A control after reset", 32'h0);
    readCheck(0, 1, 4'd8, "R1 B status after reset", 32'h00F0_0000);
    irqCheck(0, 0, "R1 A irq after reset", 1'b0);
    irqCheck(0, 1, "R1 B irq after reset", 1'b0);

    busWrite(0, 0, 4'd1, 32'hDEAD_BEEF);
    readCheck(0, 0, 4'd8, "R2 R4 A slot1 busy", 32'h00B0_0000);
    readCheck(0, 1, 4'd8, "R2 R4 B incoming1 set", 32'h04F0_0000);
    readCheck(0, 1, 4'd5, "R2 B reads word1", 32'hDEAD_BEEF);
    readCheck(0, 1, 4'd8, "R3 B incoming1 drained", 32'h00F0_0000);
    readCheck(0, 0, 4'd8, "R3 A slot1 free again", 32'h00F0_0000);
    readCheck(0, 1, 4'd5, "R3 word kept after read", 32'hDEAD_BEEF);

    busWrite(0, 1, 4'd3, 32'h1234_5678);
    readCheck(0, 0, 4'd8, "R2 R4 A incoming3", 32'h01F0_0000);
    readCheck(0, 1, 4'd8, "R2 R4 B slot3 busy", 32'h00E0_0000);
    readCheck(0, 0, 4'd7, "R2 A reads word3", 32'h1234_5678);
    readCheck(0, 0, 4'd8, "R3 A incoming3 drained", 32'h00F0_0000);

    busWrite(0, 0, 4'd9, 32'h8210_0000);
    readCheck(0, 0, 4'd9, "R5 control read-back", 32'h8210_0000);
    irqCheck(0, 0, "R9 A irq slot-free enabled", 1'b1);
    busWrite(0, 0, 4'd9, 32'h0);
    irqCheck(0, 0, "R9 A irq all masked", 1'b0);

    busWrite(0, 0, 4'd9, 32'h0002_0000);
    peekCheck(0, 0, 4'd9, "R7 request visible one cycle", 32'h0002_0000);
    readCheck(0, 0, 4'd9, "R7 request self-cleared", 32'h0);
    readCheck(0, 1, 4'd8, "R7 B doorbell2 pending", 32'h20F0_0000);
    irqCheck(0, 1, "R9 B irq doorbell masked", 1'b0);
    busWrite(0, 1, 4'd9, 32'h2000_0000);
    irqCheck(0, 1, "R9 B irq doorbell enabled", 1'b1);

    busWrite(0, 1, 4'd8, 32'h0FFF_FFFF);
    readCheck(0, 1, 4'd8, "R8 zero bits leave pending", 32'h20F0_0000);
    busWrite(0, 1, 4'd8, 32'h2000_0000);
    readCheck(0, 1, 4'd8, "R8 one clears pending", 32'h00F0_0000);
    irqCheck(0, 1, "R8 R9 B irq after ack", 1'b0);

    fork
      busWrite(0, 0, 4'd0, 32'hCAFE_F00D);
      busRead(0, 1, 4'd4, oldWord);
    join
    expQ.push_back('{"R10 collide read sees old word", 32'h0});
    actQ.push_back(oldWord);
    readCheck(0, 0, 4'd8, "R10 A slot0 busy after collide", 32'h0070_0000);
    readCheck(0, 1, 4'd8, "R10 B incoming0 after collide", 32'h08F0_0000);
    readCheck(0, 1, 4'd4, "R10 B reads new word0", 32'hCAFE_F00D);

    // ---------- compact layout ----------
    readCheck(1, 0, 4'd10, "R1 R6 A slot-free reset", 32'hF);
    readCheck(1, 0, 4'd9, "R1 R6 A incoming reset", 32'h0);
    readCheck(1, 1, 4'd8, "R1 R6 B pending reset", 32'h0);
    readCheck(1, 1, 4'd14, "R1 R6 B request reset", 32'h0);

    busWrite(1, 0, 4'd2, 32'hA5A5_A5A5);
    readCheck(1, 0, 4'd10, "R6 A slot2 busy", 32'hB);
    readCheck(1, 1, 4'd9, "R6 B incoming2", 32'h4);

    busWrite(1, 0, 4'd14, 32'h1);
    readCheck(1, 1, 4'd8, "R6 R7 B doorbell0 pending", 32'h1);
    busWrite(1, 1, 4'd11, 32'h1);
    irqCheck(1, 1, "R6 R9 B irq doorbell enabled", 1'b1);
    busWrite(1, 1, 4'd8, 32'h1);
    readCheck(1, 1, 4'd8, "R6 R8 B pending cleared", 32'h0);
    irqCheck(1, 1, "R6 R9 B irq after ack", 1'b0);

    busWrite(1, 1, 4'd12, 32'h4);
    irqCheck(1, 1, "R6 R9 B irq incoming enabled", 1'b1);
    readCheck(1, 1, 4'd6, "R6 B reads word2", 32'hA5A5_A5A5);
    irqCheck(1, 1, "R3 R9 B irq after drain", 1'b0);
    readCheck(1, 0, 4'd10, "R3 R6 A slots all free", 32'hF);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule